// File: doc/BRIEF.md
# Four-Way Dueling Configuration Selector

This block picks, for a single core, one of four candidate configurations (for instance four possible sizes of that core's private queue) by watching where that core's cache misses land. A few sets in every group of cache sets are reserved as fixed-choice samples. Two counters each compare one pair of candidates. A third counter compares the winners of the two pairs, using sets that apply the current pair winner. Every set that is not reserved receives the overall winner.

For any set index presented, the block returns the configuration that set must use. It also returns the current overall winner. Misses that another core caused are ignored. Two stability measures keep the selection from oscillating. The first is a dead band of width `HYST` on each side of zero. The second is a minimum interval of `HOLD_CYCLES` clocks between successive changes of the held choices. The counters keep counting while a change is on hold. Several copies, one per core or one per shared queue, are created outside this block.

Top module: `quadDuelSelector`

## Requirements
- R1: Configurations are encoded A=0, B=1, C=2, D=3. The slot of a set is (set index mod `GROUP_SPAN`) minus `BASE_OFFSET`. Slots 0, 1, 3 and 4 are fixed samples, and `outSel` returns A, B, C and D for them respectively.
- R2: Slot 2 returns the held winner of the A/B pair on `outSel`. Slot 5 returns the held winner of the C/D pair.
- R3: Every set outside slots 0 to 5 returns `followerSel`. `followerSel` is the A/B pair winner while the meta choice holds the A/B side, and the C/D pair winner while it holds the C/D side.
- R4: A miss in slot 0 lowers the A/B counter by one, and a miss in slot 1 raises it by one. Slots 3 and 4 do the same to the C/D counter.
- R5: A miss in slot 2 lowers the meta counter, and a miss in slot 5 raises it. Neither changes a pair counter.
- R6: A miss with `missOwn` low changes no counter.
- R7: Each held choice starts on its first option (A, C, A/B side). It moves to the second option in the clock after its counter is below −`HYST`, and it returns in the clock after its counter is above +`HYST`. Between these limits it keeps its value.
- R8: After any held choice changes, no held choice changes again for `HOLD_CYCLES` clocks. Counter updates made during that time take effect when the interval ends.
- R9: Counters are `CTR_W`-bit signed and saturate at their most positive and most negative values. They never wrap.
- R10: After reset all counters are zero, no hold interval is running, and `followerSel` is A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setIdx | input | SET_IDX_W | Index of the set being accessed or missed |
| missValid | input | 1 | A miss occurred in set `setIdx` this cycle |
| missOwn | input | 1 | The miss belongs to this core |
| outSel | output | 2 | Configuration to apply in set `setIdx` |
| followerSel | output | 2 | Configuration applied by ordinary follower sets |

## Verification
The hardest case to reach is a counter crossing its threshold while a hold interval is already running. The held choice must not change until the interval ends, and it must then take up the counter value that was reached in the meantime. The stimulus reaches this case in two steps. First, the A/B choice is flipped back, which starts the interval. In the following three clocks, three C-sample misses are issued back to back. The C/D-partial set is then probed on each cycle until the delayed change appears. Saturation is checked separately. A counter is driven well past its limit, and then the exact number of opposite misses needed to cross the far threshold is counted.

// File: rtl/duelPkg.sv
package duelPkg;

  typedef enum logic [1:0] {
    CFG_A = 2'd0,
    CFG_B = 2'd1,
    CFG_C = 2'd2,
    CFG_D = 2'd3
  } cfgSel_e;

  // Slot order is behaviour: slot number equals role code
  typedef enum logic [2:0] {
    ROLE_FIX_A   = 3'd0,
    ROLE_FIX_B   = 3'd1,
    ROLE_PART_AB = 3'd2,
    ROLE_FIX_C   = 3'd3,
    ROLE_FIX_D   = 3'd4,
    ROLE_PART_CD = 3'd5,
    ROLE_NONE    = 3'd7
  } setRole_e;

  localparam int NUM_CTR = 3;  // 0: A/B pair, 1: C/D pair, 2: meta

  typedef struct packed {
    logic incMeta;
    logic decMeta;
    logic incCD;
    logic decCD;
    logic incAB;
    logic decAB;
  } ctrStrobe_t;

endpackage

// File: rtl/duelCounters.sv
module duelCounters
  import duelPkg::*;
#(
  parameter int CTR_W = 10,
  parameter int HYST  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrStrobe_t              strobe,
  output logic signed [CTR_W-1:0] psAB,
  output logic signed [CTR_W-1:0] psCD,
  output logic signed [CTR_W-1:0] psMeta,
  output logic [NUM_CTR-1:0]      belowLow,
  output logic [NUM_CTR-1:0]      aboveHigh
);

  localparam logic signed [CTR_W-1:0] MAXV = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic signed [CTR_W-1:0] MINV = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic signed [CTR_W-1:0] ONE  = CTR_W'(1);

  logic [NUM_CTR-1:0] incV;
  logic [NUM_CTR-1:0] decV;
  logic signed [CTR_W-1:0] ctr [NUM_CTR];

  assign incV = {strobe.incMeta, strobe.incCD, strobe.incAB};
  assign decV = {strobe.decMeta, strobe.decCD, strobe.decAB};

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctr[i] <= '0;
      end else if (incV[i] && !decV[i] && (ctr[i] != MAXV)) begin
        ctr[i] <= ctr[i] + ONE;
      end else if (decV[i] && !incV[i] && (ctr[i] != MINV)) begin
        ctr[i] <= ctr[i] - ONE;
      end
    end

    assign belowLow[i]  = (int'(ctr[i]) < -HYST);
    assign aboveHigh[i] = (int'(ctr[i]) > HYST);
  end

  assign psAB   = ctr[0];
  assign psCD   = ctr[1];
  assign psMeta = ctr[2];

endmodule

// File: rtl/duelControl.sv
module duelControl
  import duelPkg::*;
#(
  parameter int SET_IDX_W   = 12,
  parameter int GROUP_SPAN  = 64,
  parameter int BASE_OFFSET = 0,
  parameter int HOLD_CYCLES = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SET_IDX_W-1:0] setIdx,
  input  logic                 missValid,
  input  logic                 missOwn,
  input  logic [NUM_CTR-1:0]   belowLow,
  input  logic [NUM_CTR-1:0]   aboveHigh,
  output ctrStrobe_t           strobe,
  output logic [1:0]           outSel,
  output logic [1:0]           followerSel
);

  localparam int SPAN_W = $clog2(GROUP_SPAN);
  localparam int TMR_W  = $clog2(HOLD_CYCLES + 1);

  logic [SPAN_W-1:0]  slot;
  int                 rel;
  setRole_e           role;
  logic               ownMiss;
  logic [NUM_CTR-1:0] held;      // 1 = second option of that choice
  logic [NUM_CTR-1:0] heldNext;
  logic [TMR_W-1:0]   holdTmr;
  cfgSel_e            winAB;
  cfgSel_e            winCD;
  cfgSel_e            winAll;

  // Role of the presented set
  assign slot = SPAN_W'(setIdx % SET_IDX_W'(GROUP_SPAN));

  always_comb begin
    rel = int'(slot) - BASE_OFFSET;
    if (rel >= 0 && rel < 6) role = setRole_e'(3'(rel));
    else                     role = ROLE_NONE;
  end

  // Counter strobes
  assign ownMiss = missValid && missOwn;

  always_comb begin
    strobe         = '0;
    strobe.decAB   = ownMiss && (role == ROLE_FIX_A);
    strobe.incAB   = ownMiss && (role == ROLE_FIX_B);
    strobe.decCD   = ownMiss && (role == ROLE_FIX_C);
    strobe.incCD   = ownMiss && (role == ROLE_FIX_D);
    strobe.decMeta = ownMiss && (role == ROLE_PART_AB);
    strobe.incMeta = ownMiss && (role == ROLE_PART_CD);
  end

  // Hysteresis: move away on low crossing, come back on high crossing
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_hyst
    assign heldNext[i] = held[i] ? !aboveHigh[i] : belowLow[i];
  end

  // Held choices with hold-off interval
  always_ff @(posedge clk) begin
    if (!rstN) begin
      held    <= '0;
      holdTmr <= '0;
    end else if (holdTmr != '0) begin
      holdTmr <= holdTmr - TMR_W'(1);
    end else if (heldNext != held) begin
      held    <= heldNext;
      holdTmr <= TMR_W'(HOLD_CYCLES - 1);
    end
  end

  assign winAB  = held[0] ? CFG_B : CFG_A;
  assign winCD  = held[1] ? CFG_D : CFG_C;
  assign winAll = held[2] ? winCD : winAB;

  always_comb begin
    unique case (role)
      ROLE_FIX_A:   outSel = CFG_A;
      ROLE_FIX_B:   outSel = CFG_B;
      ROLE_PART_AB: outSel = winAB;
      ROLE_FIX_C:   outSel = CFG_C;
      ROLE_FIX_D:   outSel = CFG_D;
      ROLE_PART_CD: outSel = winCD;
      default:      outSel = winAll;
    endcase
  end

  assign followerSel = winAll;

endmodule

// File: rtl/quadDuelSelector.sv
module quadDuelSelector
  import duelPkg::*;
#(
  parameter int SET_IDX_W   = 12,
  parameter int CTR_W       = 10,
  parameter int HYST        = 16,
  parameter int HOLD_CYCLES = 256,
  parameter int GROUP_SPAN  = 64,
  parameter int BASE_OFFSET = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SET_IDX_W-1:0] setIdx,
  input  logic                 missValid,
  input  logic                 missOwn,
  output logic [1:0]           outSel,
  output logic [1:0]           followerSel
);

  ctrStrobe_t              strobe;
  logic signed [CTR_W-1:0] psAB;
  logic signed [CTR_W-1:0] psCD;
  logic signed [CTR_W-1:0] psMeta;
  logic [NUM_CTR-1:0]      belowLow;
  logic [NUM_CTR-1:0]      aboveHigh;

  duelControl #(
    .SET_IDX_W  (SET_IDX_W),
    .GROUP_SPAN (GROUP_SPAN),
    .BASE_OFFSET(BASE_OFFSET),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .setIdx     (setIdx),
    .missValid  (missValid),
    .missOwn    (missOwn),
    .belowLow   (belowLow),
    .aboveHigh  (aboveHigh),
    .strobe     (strobe),
    .outSel     (outSel),
    .followerSel(followerSel)
  );

  duelCounters #(
    .CTR_W(CTR_W),
    .HYST (HYST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .psAB     (psAB),
    .psCD     (psCD),
    .psMeta   (psMeta),
    .belowLow (belowLow),
    .aboveHigh(aboveHigh)
  );

endmodule

// File: rtl/quadDuelSelector_chk.sv
module quadDuelSelector_chk #(
  parameter int SET_IDX_W   = 12,
  parameter int CTR_W       = 10,
  parameter int HOLD_CYCLES = 256,
  parameter int GROUP_SPAN  = 64,
  parameter int BASE_OFFSET = 0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [SET_IDX_W-1:0]    setIdx,
  input logic                    missValid,
  input logic                    missOwn,
  input logic [1:0]              outSel,
  input logic [1:0]              followerSel,
  input logic signed [CTR_W-1:0] psAB,
  input logic signed [CTR_W-1:0] psCD,
  input logic signed [CTR_W-1:0] psMeta
);

  int         chkRel;
  logic [1:0] prevFollow;
  int         gapCnt;

  assign chkRel = int'(setIdx % SET_IDX_W'(GROUP_SPAN)) - BASE_OFFSET;

  function automatic logic stepOk(input int nowV, input int oldV);
    return (nowV - oldV <= 1) && (oldV - nowV <= 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFollow <= 2'd0;
      gapCnt     <= HOLD_CYCLES;
    end else begin
      prevFollow <= followerSel;
      if (followerSel != prevFollow) gapCnt <= 0;
      else if (gapCnt < HOLD_CYCLES) gapCnt <= gapCnt + 1;
    end
  end

  // R1: fixed sample slots
  p_fixed_slots_r1: assert property (@(posedge clk) disable iff (!rstN)
    (chkRel == 0 || chkRel == 1 || chkRel == 3 || chkRel == 4)
      |-> (outSel == ((chkRel == 0) ? 2'd0 : (chkRel == 1) ? 2'd1 :
                      (chkRel == 3) ? 2'd2 : 2'd3)))
    else $error("fixed slot output wrong");

  // R2: partial slots stay within their own pair
  p_partial_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chkRel == 2 || chkRel == 5) |-> (outSel[1] == (chkRel == 5)))
    else $error("partial slot left its pair");

  // R3: ordinary sets follow the global choice
  p_follower_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chkRel < 0 || chkRel > 5) |-> (outSel == followerSel))
    else $error("follower set mismatch");

  // R6: foreign misses leave the counters alone
  p_foreign_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !missOwn) |=> ($stable(psAB) && $stable(psCD) && $stable(psMeta)))
    else $error("foreign miss moved a counter");

  // R8: follower changes are spaced by the hold interval
  p_hold_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (followerSel != prevFollow) |-> (gapCnt >= HOLD_CYCLES - 1))
    else $error("choice changed inside hold interval");

  // R9: counters move by at most one step (no wrap)
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    stepOk(int'(psAB), int'($past(psAB))) && stepOk(int'(psCD), int'($past(psCD))) &&
    stepOk(int'(psMeta), int'($past(psMeta))))
    else $error("counter jumped");

endmodule

bind quadDuelSelector quadDuelSelector_chk #(
  .SET_IDX_W  (SET_IDX_W),
  .CTR_W      (CTR_W),
  .HOLD_CYCLES(HOLD_CYCLES),
  .GROUP_SPAN (GROUP_SPAN),
  .BASE_OFFSET(BASE_OFFSET)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .setIdx     (setIdx),
  .missValid  (missValid),
  .missOwn    (missOwn),
  .outSel     (outSel),
  .followerSel(followerSel),
  .psAB       (psAB),
  .psCD       (psCD),
  .psMeta     (psMeta)
);

// File: tb/tb_quadDuelSelector.sv
module tb_quadDuelSelector;

  localparam int SET_IDX_W = 8;
  localparam int CTR_W     = 4;
  localparam int HYST      = 2;
  localparam int HOLD      = 6;
  localparam int SPAN      = 64;
  localparam int BASE      = 8;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [SET_IDX_W-1:0] setIdx = '0;
  logic                 missValid = 1'b0;
  logic                 missOwn = 1'b0;
  logic [1:0]           outSel;
  logic [1:0]           followerSel;

  typedef struct {
    int         req;
    int         idx;
    logic [1:0] expOut;
    logic [1:0] expFol;
  } sbItem_t;

  sbItem_t sbQ[$];
  int      checks = 0;
  int      errors = 0;
  bit      done = 1'b0;

  always #4 clk = ~clk;

  quadDuelSelector #(
    .SET_IDX_W  (SET_IDX_W),
    .CTR_W      (CTR_W),
    .HYST       (HYST),
    .HOLD_CYCLES(HOLD),
    .GROUP_SPAN (SPAN),
    .BASE_OFFSET(BASE)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .setIdx     (setIdx),
    .missValid  (missValid),
    .missOwn    (missOwn),
    .outSel     (outSel),
    .followerSel(followerSel)
  );

  // Set indices (base 8): A=8 B=9 AB=10 C=11 D=12 CD=13, aliases +64

  task automatic idle(input int n);
    missValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic miss(input int idx, input bit own, input int n);
    for (int k = 0; k < n; k++) begin
      setIdx    = SET_IDX_W'(idx);
      missOwn   = own;
      missValid = 1'b1;
      @(negedge clk);
    end
    missValid = 1'b0;
  endtask

  // Driver: present an index and push the expected outputs
  task automatic probe(input int idx, input logic [1:0] eo, input logic [1:0] ef,
                       input int req);
    sbItem_t it;
    missValid = 1'b0;
    setIdx    = SET_IDX_W'(idx);
    it.req = req; it.idx = idx; it.expOut = eo; it.expFol = ef;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare after the driver settles
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbQ.size() > 0) begin
        sbItem_t it;
        it = sbQ.pop_front();
        checks++;
        if (outSel !== it.expOut || followerSel !== it.expFol) begin
          errors++;
          $display("FAIL R%0d set %0d: outSel=%0d followerSel=%0d expected %0d/%0d",
                   it.req, it.idx, outSel, followerSel, it.expOut, it.expFol);
        end
      end
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state, R1 fixed slots (incl. alias), R2 partial slots
    probe(30, 2'd0, 2'd0, 10);
    probe(8,  2'd0, 2'd0, 1);
    probe(73, 2'd1, 2'd0, 1);
    probe(11, 2'd2, 2'd0, 1);
    probe(76, 2'd3, 2'd0, 1);
    probe(10, 2'd0, 2'd0, 2);
    probe(13, 2'd2, 2'd0, 2);

    // R6: foreign misses do not count; R4: own A misses lower A/B counter
    miss(8, 1'b0, 10); idle(2);
    probe(10, 2'd0, 2'd0, 6);
    miss(8, 1'b1, 2); idle(2);
    probe(10, 2'd0, 2'd0, 6);       // counter -2, no switch
    miss(8, 1'b1, 1); idle(1);
    probe(10, 2'd1, 2'd1, 4);       // -3 -> B

    // R7: back-switch needs above +HYST
    idle(8);
    miss(9, 1'b1, 5); idle(2);
    probe(10, 2'd1, 2'd1, 7);       // counter +2, still B
    miss(9, 1'b1, 1); idle(1);      // +3 -> A, hold interval starts
    // R8: C/D crossing during hold waits for the interval
    miss(11, 1'b1, 3);
    probe(13, 2'd2, 2'd0, 7);
    probe(13, 2'd2, 2'd0, 8);
    probe(13, 2'd2, 2'd0, 8);
    probe(13, 2'd3, 2'd0, 8);

    // R5: meta counter from partial slots, R3 follower tracks meta
    idle(10);
    miss(10, 1'b1, 3); idle(1);
    probe(30, 2'd3, 2'd3, 5);
    probe(10, 2'd0, 2'd3, 5);       // pair counter untouched
    idle(8);
    miss(13, 1'b1, 5); idle(2);
    probe(30, 2'd3, 2'd3, 7);
    miss(13, 1'b1, 1); idle(1);
    probe(30, 2'd0, 2'd0, 3);

    // R9: saturation high then low
    idle(8);
    miss(9, 1'b1, 18);              // +3 saturates at +7
    miss(8, 1'b1, 9); idle(2);
    probe(10, 2'd0, 2'd0, 9);       // -2
    miss(8, 1'b1, 1); idle(1);
    probe(10, 2'd1, 2'd1, 9);       // -3 -> B
    idle(8);
    miss(8, 1'b1, 20);              // saturates at -8
    miss(9, 1'b1, 10); idle(2);
    probe(10, 2'd1, 2'd1, 9);       // +2
    miss(9, 1'b1, 1); idle(1);
    probe(10, 2'd0, 2'd0, 9);       // +3 -> A

    // R4: D misses raise the C/D counter back to C
    idle(8);
    miss(12, 1'b1, 6); idle(1);
    probe(13, 2'd2, 2'd0, 4);

    idle(3);
    done = 1'b1;
    report();
  end

endmodule